// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block watches the write cycles a host issues to a parallel NOR flash device that follows the classic unlock-and-command protocol. Each write carries a byte address and a data word whose low byte is the command code. A single state machine tracks where the host stands in a command sequence. It chooses what a read returns: array data, identification words, the query table or the status word. It also raises one-cycle strobes that tell the storage datapath to program a word or to erase a sector or the whole chip.

States: `ST_READ` (idle, first unlock write expected), `ST_UNLK1` (second unlock write expected), `ST_CMD` (command byte expected), `ST_EUNLK0`/`ST_EUNLK1` (the second unlock pair of an erase), `ST_ESEL` (erase kind expected), `ST_PROG` (program data expected), `ST_ID` (identification read), `ST_CFI` (query entered from idle), `ST_ID_CFI` (query entered from identification), `ST_CHIP_ERS` and `ST_SECT_ERS` (erase running until the datapath reports completion).

Transitions:
- The unlock pair advances `ST_READ`→`ST_UNLK1`→`ST_CMD`.
- Command 0x20 keeps the machine in `ST_CMD` with bypass set. Command 0xA0 goes to `ST_PROG`, 0x90 to `ST_ID` and 0x80 to `ST_EUNLK0`. A second unlock pair then leads to `ST_ESEL`, which goes to `ST_CHIP_ERS` or `ST_SECT_ERS`.
- A query entry write leaves `ST_READ` for `ST_CFI` and leaves `ST_ID` for `ST_ID_CFI`.
- A program data write, or `erase_done` in either erase state, returns to `ST_READ`, or to `ST_CMD` while bypass is set.
- A wrong write returns to `ST_READ` and clears bypass.

Top module: `flash_cmd_seq`

## Requirements
- R1: A sequence starts only with data 0xAA at unlock word 0x555 followed by 0x55 at unlock word 0x2AA. Only the low 11 bits of the scaled address are compared. Any mismatch returns to idle reads (`rd_sel` = 0).
- R2: The third write must target word 0x555 unless bypass is set. 0xA0 selects program, 0x90 selects identification and 0x80 selects erase. Any other byte or address returns to idle. `rd_sel` encodes 0 array, 1 ID, 2 query table, 3 status. Program-pending and erase states read status.
- R3: An erase needs a second full unlock pair. After it, 0x10 at word 0x555 pulses `chip_erase_stb`, and 0x30 at any address pulses `sector_erase_stb` with `erase_addr` equal to that write's byte address. 0x10 at any other address returns to idle.
- R4: Writing 0x98 at word 0x55 from idle selects the query table (`rd_sel` = 2). A later 0xF0 or any other write returns to idle.
- R5: Writing 0x98 at word 0x55 in identification mode selects the query table, and a 0xF0 from there returns to identification mode (`rd_sel` = 1), not idle.
- R6: 0xF0 has no reset effect while an erase runs or while program data is awaited. During program it is taken as the data word.
- R7: Command 0x20 sets bypass. Command bytes are then accepted at any address without unlock, and each program or erase completion returns to the command cycle. Writing 0x00 in identification mode, or 0xF0 in the command cycle, clears bypass.
- R8: A program data write gives exactly one `prog_stb` cycle, on the clock after the write. `prog_addr` is the write address and `prog_wdata` is the new data ANDed with `prog_old`.
- R9: When `word_mode` is 1, byte addresses are shifted right by one before any comparison or identification decode. When it is 0 they are used as they are.
- R10: In identification mode, words 0 and 1 return the manufacturer and device codes and word 2 returns 0. Words 0x0E and 0x0F return the extended codes, or array data if that code is all ones. Other words return array data.
- R11: During an erase, writes cause no strobe and no change of state. `erase_done` ends the erase.
- R12: After reset, reads select the array, no strobe is active and bypass is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_mode | input | 1 | 1: 16-bit device, byte address shifted right by one |
| wr_valid | input | 1 | Host write cycle this clock |
| wr_addr | input | AW | Write byte address |
| wr_data | input | DW | Write data, low byte is the command |
| prog_old | input | DW | Current array word at `wr_addr` |
| erase_done | input | 1 | Datapath reports the erase finished |
| rd_addr | input | AW | Read byte address |
| arr_rdata | input | DW | Array data at `rd_addr` |
| cfi_rdata | input | DW | Query table data at `rd_addr` |
| stat_rdata | input | DW | Status word from the datapath |
| rd_sel | output | 2 | Read source: 0 array, 1 ID, 2 query, 3 status |
| rd_data | output | DW | Muxed read data |
| prog_stb | output | 1 | One-cycle program request |
| prog_addr | output | AW | Program byte address |
| prog_wdata | output | DW | Merged program data |
| chip_erase_stb | output | 1 | One-cycle chip erase request |
| sector_erase_stb | output | 1 | One-cycle sector erase request |
| erase_addr | output | AW | Byte address inside the sector to erase |

## Verification
On every cycle, the in-line properties check four things. At most one strobe is active at a time. A program strobe never lasts two cycles. An erase state only changes when `erase_done` arrives, including when 0xF0 is written. A 0xF0 from query-from-identification always lands in identification mode. The directed scenarios must show the rest:
- that wrong unlock or command writes really abandon the sequence, observed through a following command that is refused;
- that bypass lets commands skip the unlock and is left on 0x00;
- the identification word decode and the address scaling of both width modes.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK1,
        ST_CMD,
        ST_EUNLK0,
        ST_EUNLK1,
        ST_ESEL,
        ST_PROG,
        ST_ID,
        ST_CFI,
        ST_ID_CFI,
        ST_CHIP_ERS,
        ST_SECT_ERS
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_ARRAY  = 2'd0,
        SEL_ID     = 2'd1,
        SEL_CFI    = 2'd2,
        SEL_STATUS = 2'd3
    } rd_sel_e;

    localparam logic [7:0] CMD_UNLK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLK_B = 8'h55;
    localparam logic [7:0] CMD_BYPASS = 8'h20;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_BYP_EX = 8'h00;

endpackage

// File: rtl/fcs_addr_scale.sv
module fcs_addr_scale #(
    parameter int AW = 20,
    parameter int OW = 11
) (
    input  logic [AW-1:0] byte_addr,
    input  logic          word_mode,
    output logic [OW-1:0] cmp_addr
);
    logic unused_hi;
    assign unused_hi = ^byte_addr[AW-1:OW+1];

    always_comb begin
        if (word_mode) cmp_addr = byte_addr[OW:1];
        else           cmp_addr = byte_addr[OW-1:0];
    end
endmodule

// File: rtl/fcs_ctrl_fsm.sv
module fcs_ctrl_fsm
    import fcs_pkg::*;
#(
    parameter int          AW      = 20,
    parameter int          DW      = 16,
    parameter int          CA_W    = 11,
    parameter logic [10:0] UNLOCK0 = 11'h555,
    parameter logic [10:0] UNLOCK1 = 11'h2AA,
    parameter logic [10:0] QRY_ADR = 11'h055
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [AW-1:0]   wr_addr,
    input  logic [CA_W-1:0] cmp_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [DW-1:0]   prog_old,
    input  logic            erase_done,
    output rd_sel_e         rd_sel,
    output logic            prog_stb,
    output logic [AW-1:0]   prog_addr,
    output logic [DW-1:0]   prog_wdata,
    output logic            chip_stb,
    output logic            sect_stb,
    output logic [AW-1:0]   erase_addr
);
    localparam logic [CA_W-1:0] UA0 = UNLOCK0[CA_W-1:0];
    localparam logic [CA_W-1:0] UA1 = UNLOCK1[CA_W-1:0];
    localparam logic [CA_W-1:0] QA  = QRY_ADR[CA_W-1:0];

    seq_state_e state_q, state_nxt;
    logic       byp_q, byp_nxt;
    logic       prog_go, chip_go, sect_go, rst_seq;
    logic [7:0] cmd;

    assign cmd = wr_data[7:0];

    always_comb begin
        state_nxt = state_q;
        byp_nxt   = byp_q;
        prog_go   = 1'b0;
        chip_go   = 1'b0;
        sect_go   = 1'b0;
        rst_seq   = 1'b0;
        if (state_q == ST_CHIP_ERS || state_q == ST_SECT_ERS) begin
            if (erase_done) state_nxt = byp_q ? ST_CMD : ST_READ;
        end else if (wr_valid) begin
            if (state_q != ST_PROG && cmd == CMD_RESET) begin
                if (state_q == ST_ID_CFI) state_nxt = ST_ID;
                else                      rst_seq   = 1'b1;
            end else begin
                unique case (state_q)
                    ST_READ: begin
                        if (cmp_addr == QA && cmd == CMD_QUERY)       state_nxt = ST_CFI;
                        else if (cmd == CMD_SUSP)                     state_nxt = ST_READ;
                        else if (cmp_addr == UA0 && cmd == CMD_UNLK_A) state_nxt = ST_UNLK1;
                        else                                          rst_seq   = 1'b1;
                    end
                    ST_UNLK1: begin
                        if (cmp_addr == UA1 && cmd == CMD_UNLK_B) state_nxt = ST_CMD;
                        else                                      rst_seq   = 1'b1;
                    end
                    ST_CMD: begin
                        if (!byp_q && cmp_addr != UA0) rst_seq = 1'b1;
                        else begin
                            case (cmd)
                                CMD_BYPASS: byp_nxt   = 1'b1;
                                CMD_ERASE:  state_nxt = ST_EUNLK0;
                                CMD_IDENT:  state_nxt = ST_ID;
                                CMD_PROG:   state_nxt = ST_PROG;
                                default:    rst_seq   = 1'b1;
                            endcase
                        end
                    end
                    ST_EUNLK0: begin
                        if (cmp_addr == UA0 && cmd == CMD_UNLK_A) state_nxt = ST_EUNLK1;
                        else                                      rst_seq   = 1'b1;
                    end
                    ST_EUNLK1: begin
                        if (cmp_addr == UA1 && cmd == CMD_UNLK_B) state_nxt = ST_ESEL;
                        else                                      rst_seq   = 1'b1;
                    end
                    ST_ESEL: begin
                        if (cmd == CMD_CHIP && cmp_addr == UA0) begin
                            state_nxt = ST_CHIP_ERS;
                            chip_go   = 1'b1;
                        end else if (cmd == CMD_SECT) begin
                            state_nxt = ST_SECT_ERS;
                            sect_go   = 1'b1;
                        end else begin
                            rst_seq = 1'b1;
                        end
                    end
                    ST_PROG: begin
                        prog_go   = 1'b1;
                        state_nxt = byp_q ? ST_CMD : ST_READ;
                    end
                    ST_ID: begin
                        if (byp_q && cmd == CMD_BYP_EX)               rst_seq   = 1'b1;
                        else if (cmp_addr == QA && cmd == CMD_QUERY)  state_nxt = ST_ID_CFI;
                        else                                          rst_seq   = 1'b1;
                    end
                    ST_CFI, ST_ID_CFI:            rst_seq = 1'b1;
                    ST_CHIP_ERS, ST_SECT_ERS:     rst_seq = 1'b0;
                endcase
            end
        end
        if (rst_seq) begin
            state_nxt = ST_READ;
            byp_nxt   = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READ;
            byp_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            byp_q   <= byp_nxt;
        end
    end

    // registered strobes toward the datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_stb   <= 1'b0;
            chip_stb   <= 1'b0;
            sect_stb   <= 1'b0;
            prog_addr  <= '0;
            prog_wdata <= '0;
            erase_addr <= '0;
        end else begin
            prog_stb <= prog_go;
            chip_stb <= chip_go;
            sect_stb <= sect_go;
            if (prog_go) begin
                prog_addr  <= wr_addr;
                prog_wdata <= wr_data & prog_old;
            end
            if (sect_go) erase_addr <= wr_addr;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ID:                               rd_sel = SEL_ID;
            ST_CFI, ST_ID_CFI:                   rd_sel = SEL_CFI;
            ST_PROG, ST_CHIP_ERS, ST_SECT_ERS:   rd_sel = SEL_STATUS;
            default:                             rd_sel = SEL_ARRAY;
        endcase
    end

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_stb, chip_stb, sect_stb}));

    p_prog_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_stb |=> !prog_stb);

    p_sect_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sect_stb |-> (state_q == ST_SECT_ERS || erase_done));

    p_erase_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CHIP_ERS || state_q == ST_SECT_ERS) && !erase_done)
        |=> (state_q == $past(state_q)));

    p_reset_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CHIP_ERS || state_q == ST_SECT_ERS) && wr_valid
         && cmd == CMD_RESET && !erase_done) |=> !prog_stb && !chip_stb && !sect_stb);

    p_qry_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ID_CFI && wr_valid && cmd == CMD_RESET) |=> (state_q == ST_ID));

endmodule

// File: rtl/fcs_read_mux.sv
module fcs_read_mux
    import fcs_pkg::*;
#(
    parameter int          DW      = 16,
    parameter logic [15:0] ID_MFR  = 16'h0001,
    parameter logic [15:0] ID_DEV  = 16'h227E,
    parameter logic [15:0] ID_EXTA = 16'h2222,
    parameter logic [15:0] ID_EXTB = 16'hFFFF
) (
    input  rd_sel_e       rd_sel,
    input  logic [7:0]    word_addr,
    input  logic [DW-1:0] arr_rdata,
    input  logic [DW-1:0] cfi_rdata,
    input  logic [DW-1:0] stat_rdata,
    output logic [DW-1:0] rd_data
);
    localparam logic [DW-1:0] MFR_W  = DW'(ID_MFR);
    localparam logic [DW-1:0] DEV_W  = DW'(ID_DEV);
    localparam logic [DW-1:0] EXTA_W = DW'(ID_EXTA);
    localparam logic [DW-1:0] EXTB_W = DW'(ID_EXTB);

    logic [DW-1:0] id_word;

    always_comb begin
        unique case (word_addr)
            8'h00:   id_word = MFR_W;
            8'h01:   id_word = DEV_W;
            8'h02:   id_word = '0;
            8'h0E:   id_word = (EXTA_W == '1) ? arr_rdata : EXTA_W;
            8'h0F:   id_word = (EXTB_W == '1) ? arr_rdata : EXTB_W;
            default: id_word = arr_rdata;
        endcase
    end

    always_comb begin
        unique case (rd_sel)
            SEL_ID:     rd_data = id_word;
            SEL_CFI:    rd_data = cfi_rdata;
            SEL_STATUS: rd_data = stat_rdata;
            default:    rd_data = arr_rdata;
        endcase
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int          AW      = 20,
    parameter int          DW      = 16,
    parameter logic [10:0] UNLOCK0 = 11'h555,
    parameter logic [10:0] UNLOCK1 = 11'h2AA,
    parameter logic [15:0] ID_MFR  = 16'h0001,
    parameter logic [15:0] ID_DEV  = 16'h227E,
    parameter logic [15:0] ID_EXTA = 16'h2222,
    parameter logic [15:0] ID_EXTB = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_mode,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] prog_old,
    input  logic          erase_done,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_rdata,
    input  logic [DW-1:0] cfi_rdata,
    input  logic [DW-1:0] stat_rdata,
    output logic [1:0]    rd_sel,
    output logic [DW-1:0] rd_data,
    output logic          prog_stb,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_wdata,
    output logic          chip_erase_stb,
    output logic          sector_erase_stb,
    output logic [AW-1:0] erase_addr
);
    localparam int CA_W = 11;
    localparam int RA_W = 8;

    logic [CA_W-1:0] wr_cmp;
    logic [RA_W-1:0] rd_word;
    rd_sel_e         sel;

    fcs_addr_scale #(.AW(AW), .OW(CA_W)) u_wr_scale (
        .byte_addr(wr_addr), .word_mode(word_mode), .cmp_addr(wr_cmp));

    fcs_addr_scale #(.AW(AW), .OW(RA_W)) u_rd_scale (
        .byte_addr(rd_addr), .word_mode(word_mode), .cmp_addr(rd_word));

    fcs_ctrl_fsm #(
        .AW(AW), .DW(DW), .CA_W(CA_W), .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .cmp_addr(wr_cmp), .wr_data(wr_data), .prog_old(prog_old),
        .erase_done(erase_done), .rd_sel(sel), .prog_stb(prog_stb),
        .prog_addr(prog_addr), .prog_wdata(prog_wdata), .chip_stb(chip_erase_stb),
        .sect_stb(sector_erase_stb), .erase_addr(erase_addr));

    fcs_read_mux #(
        .DW(DW), .ID_MFR(ID_MFR), .ID_DEV(ID_DEV), .ID_EXTA(ID_EXTA), .ID_EXTB(ID_EXTB)
    ) u_rmux (
        .rd_sel(sel), .word_addr(rd_word), .arr_rdata(arr_rdata),
        .cfi_rdata(cfi_rdata), .stat_rdata(stat_rdata), .rd_data(rd_data));

    assign rd_sel = sel;
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          word_mode = 1'b1;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] prog_old = 16'h5A5A;
    logic          erase_done = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_rdata = 16'hA5C3;
    logic [DW-1:0] cfi_rdata = 16'h0051;
    logic [DW-1:0] stat_rdata = 16'h0080;
    logic [1:0]    rd_sel;
    logic [DW-1:0] rd_data;
    logic          prog_stb, chip_erase_stb, sector_erase_stb;
    logic [AW-1:0] prog_addr, erase_addr;
    logic [DW-1:0] prog_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // word-mode byte addresses
    localparam logic [AW-1:0] A_U0  = 20'h00AAA;
    localparam logic [AW-1:0] A_U1  = 20'h00554;
    localparam logic [AW-1:0] A_QRY = 20'h000AA;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .prog_old(prog_old),
        .erase_done(erase_done), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
        .cfi_rdata(cfi_rdata), .stat_rdata(stat_rdata), .rd_sel(rd_sel),
        .rd_data(rd_data), .prog_stb(prog_stb), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .chip_erase_stb(chip_erase_stb),
        .sector_erase_stb(sector_erase_stb), .erase_addr(erase_addr));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = {8'h00, d};
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic unlock();
        wr(A_U0, 8'hAA);
        wr(A_U1, 8'h55);
    endtask

    task automatic pulse_done();
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 rd_sel", rd_sel, 0);
        check("R12 strobes", {prog_stb, chip_erase_stb, sector_erase_stb}, 0);
        check("R12 rd_data", rd_data, arr_rdata);
    endtask

    task automatic t_program();
        unlock();
        wr(A_U0, 8'hA0);
        check("R2 program selects status", rd_sel, 3);
        check("R2 status data", rd_data, 16'h0080);
        prog_old = 16'hF0F0;
        wr_word(20'h00100, 16'h1234);
        check("R8 prog_stb", prog_stb, 1);
        check("R8 prog_wdata", prog_wdata, 16'h1030);
        check("R8 prog_addr", prog_addr, 20'h00100);
        check("R8 back to read", rd_sel, 0);
        @(negedge clk);
        check("R8 single pulse", prog_stb, 0);
    endtask

    task automatic t_bad_unlock();
        wr(A_U0, 8'hAA);
        wr(20'h00556, 8'h55);
        wr(A_U0, 8'hA0);
        check("R1 wrong second address", rd_sel, 0);
        wr(A_U0, 8'hAB);
        wr(A_U1, 8'h55);
        wr(A_U0, 8'hA0);
        check("R1 wrong first data", rd_sel, 0);
        // high bits beyond 11 are ignored: word 0x855 -> 0x055? use 0x1555
        wr(20'h02AAA, 8'hAA);
        wr(A_U1, 8'h55);
        wr(A_U0, 8'hA0);
        check("R1 high address bits ignored", rd_sel, 3);
        wr_word(20'h00010, 16'hFFFF);
    endtask

    task automatic t_bad_cmd();
        unlock();
        wr(A_U0, 8'h77);
        check("R2 unknown command", rd_sel, 0);
        wr(A_U0, 8'hA0);
        check("R2 no unlock after reset", rd_sel, 0);
        unlock();
        wr(20'h00010, 8'hA0);
        check("R2 wrong command address", rd_sel, 0);
    endtask

    task automatic t_id();
        unlock();
        wr(A_U0, 8'h90);
        check("R2 ident selected", rd_sel, 1);
        rd_addr = 20'h00000; #1 check("R10 mfr", rd_data, 16'h0001);
        rd_addr = 20'h00002; #1 check("R10 dev / R9 scaling", rd_data, 16'h227E);
        rd_addr = 20'h00004; #1 check("R10 protect word", rd_data, 16'h0000);
        rd_addr = 20'h0001C; #1 check("R10 ext A", rd_data, 16'h2222);
        rd_addr = 20'h0001E; #1 check("R10 ext B all ones", rd_data, arr_rdata);
        rd_addr = 20'h00040; #1 check("R10 other word", rd_data, arr_rdata);
        word_mode = 1'b0;
        rd_addr = 20'h00001; #1 check("R9 byte mode dev", rd_data, 16'h227E);
        word_mode = 1'b1;
        rd_addr = '0;
        wr(20'h0, 8'hF0);
        check("R10 exit ident", rd_sel, 0);
    endtask

    task automatic t_cfi();
        wr(A_QRY, 8'h98);
        check("R4 query entry", rd_sel, 2);
        check("R4 query data", rd_data, 16'h0051);
        wr(20'h0, 8'hF0);
        check("R4 reset to read", rd_sel, 0);
        wr(A_QRY, 8'h98);
        wr(20'h00020, 8'h12);
        check("R4 other write leaves query", rd_sel, 0);
    endtask

    task automatic t_id_cfi();
        unlock();
        wr(A_U0, 8'h90);
        wr(A_QRY, 8'h98);
        check("R5 query from ident", rd_sel, 2);
        wr(20'h0, 8'hF0);
        check("R5 reset returns to ident", rd_sel, 1);
        wr(20'h0, 8'hF0);
        check("R5 second reset to read", rd_sel, 0);
    endtask

    task automatic erase_setup();
        unlock();
        wr(A_U0, 8'h80);
        unlock();
    endtask

    task automatic t_chip();
        erase_setup();
        wr(A_U0, 8'h10);
        check("R3 chip strobe", chip_erase_stb, 1);
        check("R3 chip status", rd_sel, 3);
        wr(20'h0, 8'hF0);
        check("R6 reset ignored in erase", rd_sel, 3);
        wr(20'h00200, 8'h30);
        check("R11 no strobe in erase", {prog_stb, chip_erase_stb, sector_erase_stb}, 0);
        check("R11 still erasing", rd_sel, 3);
        pulse_done();
        check("R11 done to read", rd_sel, 0);
        erase_setup();
        wr(20'h00100, 8'h10);
        check("R3 chip wrong address", {chip_erase_stb, 6'(rd_sel)}, 0);
    endtask

    task automatic t_sector();
        erase_setup();
        wr(20'h04000, 8'h30);
        check("R3 sector strobe", sector_erase_stb, 1);
        check("R3 erase_addr", erase_addr, 20'h04000);
        @(negedge clk);
        check("R3 sector pulse ends", sector_erase_stb, 0);
        check("R11 erase holds", rd_sel, 3);
        pulse_done();
        check("R11 sector done", rd_sel, 0);
    endtask

    task automatic t_prog_f0();
        unlock();
        wr(A_U0, 8'hA0);
        prog_old = 16'hFF5A;
        wr_word(20'h00300, 16'h00F0);
        check("R6 F0 taken as data", prog_stb, 1);
        check("R6 F0 data merged", prog_wdata, 16'h0050);
    endtask

    task automatic t_bypass();
        prog_old = 16'hFFFF;
        unlock();
        wr(A_U0, 8'h20);
        check("R7 bypass idle reads array", rd_sel, 0);
        wr(20'h00300, 8'hA0);
        check("R7 program any address", rd_sel, 3);
        wr_word(20'h00400, 16'h0F0F);
        check("R7 bypass program strobe", prog_stb, 1);
        check("R7 bypass program data", prog_wdata, 16'h0F0F);
        wr(20'h00302, 8'hA0);
        check("R7 back at command cycle", rd_sel, 3);
        wr_word(20'h00402, 16'h1111);
        wr(20'h00010, 8'h80);
        unlock();
        wr(20'h08000, 8'h30);
        check("R7 bypass sector erase", sector_erase_stb, 1);
        pulse_done();
        wr(20'h00012, 8'hA0);
        check("R7 erase completion keeps bypass", rd_sel, 3);
        wr_word(20'h00404, 16'h2222);
        wr(20'h00014, 8'h90);
        check("R7 bypass ident", rd_sel, 1);
        wr(20'h00014, 8'h00);
        check("R7 exit via 00", rd_sel, 0);
        wr(A_U0, 8'hA0);
        check("R7 bypass cleared", rd_sel, 0);
        unlock();
        wr(A_U0, 8'h20);
        wr(20'h0, 8'hF0);
        wr(20'h00300, 8'hA0);
        check("R7 F0 clears bypass", rd_sel, 0);
    endtask

    task automatic t_byte_mode();
        word_mode = 1'b0;
        wr(20'h00555, 8'hAA);
        wr(20'h002AA, 8'h55);
        wr(20'h00555, 8'hA0);
        check("R9 byte mode unlock", rd_sel, 3);
        wr_word(20'h00001, 16'h0001);
        word_mode = 1'b1;
        wr(20'h00555, 8'hAA);
        wr(20'h002AA, 8'h55);
        check("R9 word mode rejects byte addresses", rd_sel, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_bad_unlock();
        t_bad_cmd();
        t_id();
        t_cfi();
        t_id_cfi();
        t_chip();
        t_sector();
        t_prog_f0();
        t_bypass();
        t_byte_mode();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule